// File: doc/BRIEF.md
# Garbage-Collected Two-Pointer Record Store

This block is the storage system that sits underneath a list evaluator. It holds a small, fixed array of records. Each record has two typed pointers, called car and cdr. The requester sees an allocator that never runs dry. It issues one request at a time on a valid/acknowledge handshake. A request either reads one field of an existing record or creates a new record from two pointers.

New records come from a free list that is threaded through the cdr fields of the unused cells. When a create request finds the free list empty, the block holds back the acknowledge and runs a mark-and-sweep collection with its own controller. Marking starts from a set of root pointers that the requester supplies, plus the two operands of the pending request. Marking follows only list-typed pointers and uses an explicit stack, so no recursion depth is assumed. The sweep then walks every cell in address order, rebuilds the free list and clears the marks. After that the pending request completes, or it reports out-of-memory if nothing could be reclaimed.

The controller moves every pointer under inspection (root, operand, car field, cdr field) over one internal bus. This bus is private to the block and is separate from anything the evaluator owns.

Top module: `lrs_storage_mgr`

## Requirements
- R1: After reset, `ack`, `rsp_err` and `rsp_oom` are low. Every cell is free, and the first create request returns the cell at address NCELLS-1.
- R2: A pointer is 11 bits wide: type in bits [10:8] and address in bits [7:0]. Type 0 is NIL, and the NIL pointer is all zeros. Type 1 is a list record. Types 2 to 7 are atoms and constants. A created record is returned as a type-1 pointer that carries its cell address.
- R3: `req_op` 0 reads the car field and 1 reads the cdr field. When `req_a` is list-typed, the stored field is returned with `ack` high one cycle after the request is accepted in the idle state.
- R4: A car or cdr request on a pointer that is not list-typed returns NIL with `rsp_err` high and does not read memory. Op code 3 is treated the same way.
- R5: `req_op` 2 creates a record with car=`req_a` and cdr=`req_b`. While a free cell exists it completes in one cycle. Free cells are handed out last-in first-out, so right after reset the addresses come out in descending order.
- R6: `ack` is a single-cycle pulse. After an `ack`, no new request is accepted until `req_valid` has been seen low for one cycle.
- R7: A create request that finds no free cell gets no `ack` while the collector runs. Records reachable from the roots or from `req_a`/`req_b` survive with their contents, and every other record is reclaimed. The request then completes. `req_*` and `roots` must be held stable until `ack`.
- R8: Only type-1 pointers are followed during marking. A record referenced only by an atom or constant whose address field happens to match it is reclaimed.
- R9: The sweep visits cells from address 0 upward and pushes each unreached cell onto the free list. After a collection, cells are therefore reused from the highest free address downward. Every mark is clear again when the block returns to idle.
- R10: If a collection frees no cell, the create request completes with NIL and `rsp_oom` high, and all stored records are left intact.
- R11: `rsp_err` and `rsp_oom` are high only in the cycle `ack` is high. A later successful request returns them low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `ack` |
| req_op | input | 2 | 0 car, 1 cdr, 2 create, 3 invalid |
| req_a | input | 11 | Pointer to read, or car of new record |
| req_b | input | 11 | cdr of new record |
| roots | input | NROOTS*11 | Root pointers for marking, root k at bits [11k+10:11k] |
| ack | output | 1 | One-cycle completion pulse |
| rsp_ptr | output | 11 | Result pointer, valid with `ack` |
| rsp_err | output | 1 | Field read on a non-list pointer or invalid op |
| rsp_oom | output | 1 | Create failed after collection |

## Verification
The bench first fills the whole array. It then triggers a collection with a deliberately mixed root set: a list root that reaches a second cell through its cdr, an atom whose address field names a live-looking cell, a list root and a NIL root. The pending create's cdr operand also points at an otherwise unrooted cell. After the collection the exact sequence of reused addresses is checked. A collector that followed atoms would never hand out cell 3. One that ignored the operands would hand out cell 7. One that skipped cdr links would lose cell 15. A sweep with the wrong linking order would produce a different sequence. The bench then makes every cell reachable through a long chain, which checks that out-of-memory returns NIL without corrupting the chain. Releasing the chain root checks that a later create recovers. Non-list reads, the invalid op code and holding `req_valid` after an `ack` are also checked. A design with sticky error flags or a re-triggering acknowledge would fail those checks.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int TYPE_W = 3;
  localparam int ADDR_W = 8;
  localparam int PTR_W  = TYPE_W + ADDR_W;

  localparam logic [TYPE_W-1:0] TY_NIL  = 3'd0;
  localparam logic [TYPE_W-1:0] TY_LIST = 3'd1;

  typedef struct packed {
    logic [TYPE_W-1:0] typ;
    logic [ADDR_W-1:0] addr;
  } ptr_t;

  localparam ptr_t NIL_PTR = '{typ: TY_NIL, addr: '0};

  localparam logic [1:0] OP_CAR  = 2'd0;
  localparam logic [1:0] OP_CDR  = 2'd1;
  localparam logic [1:0] OP_CONS = 2'd2;

  function automatic logic is_list(ptr_t p);
    return p.typ == TY_LIST;
  endfunction

  function automatic ptr_t mk_list(logic [ADDR_W-1:0] a);
    return '{typ: TY_LIST, addr: a};
  endfunction
endpackage

// File: rtl/lrs_cell_store.sv
module lrs_cell_store
  import lrs_pkg::*;
#(
  parameter int NCELLS = 16,
  parameter int IDX_W  = $clog2(NCELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ptr_t             rd_car,
  output ptr_t             rd_cdr,
  input  logic             wr_cell_en,
  input  logic             wr_cdr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ptr_t             wr_car,
  input  ptr_t             wr_cdr,
  input  logic             mark_set_en,
  input  logic             mark_clr_en,
  input  logic [IDX_W-1:0] mark_idx,
  output logic [NCELLS-1:0] marks
);
  ptr_t car_mem [NCELLS];
  ptr_t cdr_mem [NCELLS];

  assign rd_car = car_mem[rd_idx];
  assign rd_cdr = cdr_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_cell_en) car_mem[wr_idx] <= wr_car;
    if (wr_cell_en || wr_cdr_en) cdr_mem[wr_idx] <= wr_cdr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) marks <= '0;
    else if (mark_set_en) marks[mark_idx] <= 1'b1;
    else if (mark_clr_en) marks[mark_idx] <= 1'b0;
  end

  AST_MARK_SET_CLEAR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_set_en && mark_clr_en)); // R9
endmodule

// File: rtl/lrs_mark_stack.sv
module lrs_mark_stack #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop_en,
  output logic [IDX_W-1:0] top_idx,
  output logic             empty
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  sp_m1;

  assign sp_m1   = sp - SP_W'(1);
  assign top_idx = mem[sp_m1[IDX_W-1:0]];
  assign empty   = (sp == '0);

  always_ff @(posedge clk) begin
    if (push_en) mem[sp[IDX_W-1:0]] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= '0;
    else if (push_en) sp <= sp + SP_W'(1);
    else if (pop_en) sp <= sp_m1;
  end

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (sp < SP_W'(DEPTH))); // R7
  AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !empty); // R7
  AST_STACK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop_en)); // R7
endmodule

// File: rtl/lrs_storage_mgr.sv
module lrs_storage_mgr
  import lrs_pkg::*;
#(
  parameter int NCELLS = 16,
  parameter int NROOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [PTR_W-1:0]        req_a,
  input  logic [PTR_W-1:0]        req_b,
  input  logic [NROOTS*PTR_W-1:0] roots,
  output logic                    ack,
  output logic [PTR_W-1:0]        rsp_ptr,
  output logic                    rsp_err,
  output logic                    rsp_oom
);
  localparam int IDX_W   = $clog2(NCELLS);
  localparam int RI_LAST = NROOTS + 1;
  localparam int RI_W    = $clog2(NROOTS + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_DROP, S_MARK_ROOT, S_MARK_POP,
    S_MARK_CAR, S_MARK_CDR, S_SWEEP, S_ALLOC
  } state_e;

  state_e           state;
  logic [IDX_W-1:0] head, sidx, cur, rd_idx, mark_idx, top_idx;
  logic             free_ok, init_q, stk_empty;
  logic [RI_W-1:0]  ri;
  logic [1:0]       op_q;
  logic [NCELLS-1:0] marks;
  ptr_t a_p, b_p, root_p, gbus, rd_car, rd_cdr, sweep_link;
  logic [IDX_W-1:0] gidx;
  logic scan, push_en, pop_en, alloc_go, sweep_free, wr_cdr_en;
  logic unused_hi;

  assign a_p = ptr_t'(req_a);
  assign b_p = ptr_t'(req_b);

  always_comb begin
    root_p = b_p;
    if (ri == RI_W'(NROOTS)) root_p = a_p;
    for (int k = 0; k < NROOTS; k++)
      if (ri == RI_W'(k)) root_p = ptr_t'(roots[k*PTR_W +: PTR_W]);
  end

  // Private collector bus: one pointer under inspection per cycle.
  always_comb begin
    case (state)
      S_MARK_ROOT: gbus = root_p;
      S_MARK_CAR:  gbus = rd_car;
      S_MARK_CDR:  gbus = rd_cdr;
      default:     gbus = NIL_PTR;
    endcase
  end

  assign gidx    = gbus.addr[IDX_W-1:0];
  assign scan    = (state == S_MARK_ROOT) || (state == S_MARK_CAR) || (state == S_MARK_CDR);
  assign push_en = scan && is_list(gbus) && !marks[gidx];
  assign pop_en  = (state == S_MARK_POP) && !stk_empty;

  assign alloc_go = free_ok && (((state == S_IDLE) && req_valid && req_op == OP_CONS)
                                || (state == S_ALLOC));
  assign sweep_free = (state == S_SWEEP) && !marks[sidx];
  assign wr_cdr_en  = sweep_free;
  assign sweep_link = free_ok ? mk_list(ADDR_W'(head)) : NIL_PTR;
  assign mark_idx   = push_en ? gidx : sidx;

  always_comb begin
    if (state == S_MARK_CAR || state == S_MARK_CDR) rd_idx = cur;
    else if (state == S_IDLE && req_op != OP_CONS)  rd_idx = a_p.addr[IDX_W-1:0];
    else                                            rd_idx = head;
  end

  assign unused_hi = ^{gbus, rd_cdr, a_p};

  lrs_cell_store #(.NCELLS(NCELLS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_car(rd_car), .rd_cdr(rd_cdr),
    .wr_cell_en(alloc_go), .wr_cdr_en(wr_cdr_en),
    .wr_idx(alloc_go ? head : sidx), .wr_car(a_p),
    .wr_cdr(alloc_go ? b_p : sweep_link),
    .mark_set_en(push_en), .mark_clr_en((state == S_SWEEP) && marks[sidx]),
    .mark_idx(mark_idx), .marks(marks)
  );

  lrs_mark_stack #(.DEPTH(NCELLS), .IDX_W(IDX_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_idx(gidx),
    .pop_en(pop_en), .top_idx(top_idx), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_SWEEP; sidx <= '0; init_q <= 1'b1; free_ok <= 1'b0;
      head <= '0; cur <= '0; ri <= '0; op_q <= OP_CAR;
      ack <= 1'b0; rsp_ptr <= '0; rsp_err <= 1'b0; rsp_oom <= 1'b0;
    end else begin
      ack <= 1'b0; rsp_err <= 1'b0; rsp_oom <= 1'b0;
      if (alloc_go) begin
        rsp_ptr <= mk_list(ADDR_W'(head));
        head    <= rd_cdr.addr[IDX_W-1:0];
        free_ok <= is_list(rd_cdr);
        ack     <= 1'b1;
        state   <= S_WAIT_DROP;
      end else begin
        case (state)
          S_IDLE: if (req_valid) begin
            op_q <= req_op;
            if (req_op == OP_CONS) begin
              state <= S_MARK_ROOT; ri <= '0;
            end else begin
              ack <= 1'b1; state <= S_WAIT_DROP;
              if (req_op != OP_CONS + 2'd1 && is_list(a_p))
                rsp_ptr <= (req_op == OP_CAR) ? rd_car : rd_cdr;
              else begin
                rsp_ptr <= NIL_PTR; rsp_err <= 1'b1;
              end
            end
          end
          S_WAIT_DROP: if (!req_valid) state <= S_IDLE;
          S_MARK_ROOT: begin
            if (ri == RI_W'(RI_LAST)) state <= S_MARK_POP;
            else ri <= ri + RI_W'(1);
          end
          S_MARK_POP: begin
            if (stk_empty) begin
              state <= S_SWEEP; sidx <= '0; free_ok <= 1'b0;
            end else begin
              cur <= top_idx; state <= S_MARK_CAR;
            end
          end
          S_MARK_CAR: state <= S_MARK_CDR;
          S_MARK_CDR: state <= S_MARK_POP;
          S_SWEEP: begin
            if (sweep_free) begin
              head <= sidx; free_ok <= 1'b1;
            end
            if (sidx == IDX_W'(NCELLS - 1)) begin
              init_q <= 1'b0;
              state  <= init_q ? S_IDLE : S_ALLOC;
            end else sidx <= sidx + IDX_W'(1);
          end
          S_ALLOC: begin  // reached only with free_ok low
            rsp_ptr <= NIL_PTR; rsp_oom <= 1'b1; ack <= 1'b1;
            state <= S_WAIT_DROP;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R6
  AST_ERR_GIVES_NIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rsp_err) |-> (rsp_ptr == NIL_PTR)); // R4
  AST_OOM_GIVES_NIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rsp_oom) |-> (rsp_ptr == NIL_PTR)); // R10
  AST_FLAGS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (!rsp_err && !rsp_oom)); // R11
  AST_CONS_IS_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && op_q == OP_CONS && !rsp_oom) |-> (rsp_ptr[PTR_W-1:ADDR_W] == TY_LIST)); // R5
  AST_MARKS_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (marks == '0)); // R9
  AST_NO_ACK_IN_GC: assert property (@(posedge clk) disable iff (!rst_n)
    (scan || state == S_MARK_POP || (state == S_SWEEP && !init_q)) |=> !ack); // R7
endmodule

// File: tb/lrs_storage_mgr_tb.sv
module lrs_storage_mgr_tb;
  localparam int NC = 16;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [10:0] req_a = '0, req_b = '0;
  logic [NR*11-1:0] roots = '0;
  logic ack, rsp_err, rsp_oom;
  logic [10:0] rsp_ptr;

  int n_chk = 0, n_bad = 0;
  logic [10:0] r_ptr;
  logic r_err, r_oom;
  int r_lat;

  always #5 clk = ~clk;

  lrs_storage_mgr #(.NCELLS(NC), .NROOTS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_a(req_a), .req_b(req_b), .roots(roots), .ack(ack),
    .rsp_ptr(rsp_ptr), .rsp_err(rsp_err), .rsp_oom(rsp_oom));

  function automatic logic [10:0] lst(int a); return {3'd1, 8'(a)}; endfunction
  function automatic logic [10:0] atm(int a); return {3'd2, 8'(a)}; endfunction
  localparam logic [10:0] NILP = 11'd0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_req(logic [1:0] op, logic [10:0] a, logic [10:0] b, int hold);
    req_op = op; req_a = a; req_b = b; req_valid = 1'b1;
    r_lat = 0;
    do begin
      @(negedge clk); r_lat++;
      if (r_lat > 5000) begin
        chk("watchdog", 0, 1); finish_run();
      end
    end while (!ack);
    r_ptr = rsp_ptr; r_err = rsp_err; r_oom = rsp_oom;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R6 no re-ack while valid held", 32'(ack), 0);
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ack low after reset", 32'(ack), 0);
    chk("R1 err low after reset", 32'(rsp_err), 0);
    chk("R11 oom low after reset", 32'(rsp_oom), 0);
  endtask

  task automatic t_basic();
    do_req(2'd2, atm(5), NILP, 0);
    chk("R1 first create at top cell", 32'(r_ptr), 32'(lst(NC-1)));
    chk("R2 created type bits", 32'(r_ptr[10:8]), 1);
    do_req(2'd2, atm(6), lst(NC-1), 0);
    chk("R5 second create descends", 32'(r_ptr), 32'(lst(NC-2)));
    chk("R5 create latency", r_lat, 1);
    do_req(2'd0, lst(14), NILP, 0);
    chk("R3 car field", 32'(r_ptr), 32'(atm(6)));
    chk("R3 read latency", r_lat, 1);
    do_req(2'd1, lst(14), NILP, 0);
    chk("R3 cdr field", 32'(r_ptr), 32'(lst(15)));
    do_req(2'd1, lst(15), NILP, 0);
    chk("R3 cdr NIL end", 32'(r_ptr), 32'(NILP));
    chk("R3 no err", 32'(r_err), 0);
  endtask

  task automatic t_nonlist();
    do_req(2'd0, atm(14), NILP, 0);
    chk("R4 car of atom nil", 32'(r_ptr), 0);
    chk("R4 car of atom err", 32'(r_err), 1);
    do_req(2'd1, NILP, NILP, 0);
    chk("R4 cdr of NIL err", 32'({r_err, r_ptr}), 32'({1'b1, NILP}));
    do_req(2'd0, {3'd7, 8'd14}, NILP, 0);
    chk("R4 car of constant", 32'({r_err, r_ptr}), 32'({1'b1, NILP}));
    do_req(2'd3, lst(14), NILP, 0);
    chk("R4 op 3 invalid", 32'({r_err, r_ptr}), 32'({1'b1, NILP}));
    do_req(2'd0, lst(14), NILP, 0);
    chk("R11 err clears on good read", 32'(r_err), 0);
    chk("R11 good read value", 32'(r_ptr), 32'(atm(6)));
  endtask

  task automatic t_hold();
    do_req(2'd0, lst(15), NILP, 3);
    chk("R6 held read value", 32'(r_ptr), 32'(atm(5)));
  endtask

  task automatic t_fill();
    for (int c = NC - 3; c >= 0; c--) begin
      do_req(2'd2, atm(c), NILP, 0);
      chk("R5 fill order", 32'(r_ptr), 32'(lst(c)));
    end
  endtask

  task automatic t_gc();
    logic [10:0] prev;
    roots = {NILP, lst(5), atm(3), lst(14)};
    do_req(2'd2, atm(9), lst(7), 0);
    chk("R7 create completes after GC", 32'(r_ptr), 32'(lst(13)));
    chk("R7 create was held back", 32'(r_lat > NC), 1);
    chk("R7 oom low", 32'(r_oom), 0);
    do_req(2'd1, lst(13), NILP, 0);
    chk("R7 new record cdr", 32'(r_ptr), 32'(lst(7)));
    do_req(2'd0, lst(14), NILP, 0);
    chk("R7 root record kept", 32'(r_ptr), 32'(atm(6)));
    do_req(2'd0, lst(15), NILP, 0);
    chk("R7 cdr-reached record kept", 32'(r_ptr), 32'(atm(5)));
    do_req(2'd0, lst(7), NILP, 0);
    chk("R7 operand-reached record kept", 32'(r_ptr), 32'(atm(7)));
    prev = lst(13);
    for (int c = 12; c >= 0; c--) begin
      if (c == 5 || c == 7) continue;
      do_req(2'd2, atm(c), prev, 0);
      if (c == 3) chk("R8 atom-named cell reclaimed", 32'(r_ptr), 32'(lst(3)));
      else chk("R9 reuse order after sweep", 32'(r_ptr), 32'(lst(c)));
      prev = r_ptr;
    end
  endtask

  task automatic t_oom();
    roots = {NILP, lst(5), lst(0), lst(14)};
    do_req(2'd2, atm(1), NILP, 0);
    chk("R10 oom result NIL", 32'(r_ptr), 0);
    chk("R10 oom flag", 32'(r_oom), 1);
    do_req(2'd1, lst(0), NILP, 0);
    chk("R10 chain intact", 32'(r_ptr), 32'(lst(1)));
    chk("R11 oom clears", 32'(r_oom), 0);
    do_req(2'd0, lst(6), NILP, 0);
    chk("R10 deep cell intact", 32'(r_ptr), 32'(atm(6)));
  endtask

  task automatic t_recover();
    roots = {NILP, lst(5), NILP, lst(14)};
    do_req(2'd2, atm(2), NILP, 0);
    chk("R7 recovery after release", 32'(r_ptr), 32'(lst(13)));
    chk("R7 recovery no oom", 32'(r_oom), 0);
    do_req(2'd2, atm(2), NILP, 0);
    chk("R9 next reuse", 32'(r_ptr), 32'(lst(12)));
    do_req(2'd0, lst(5), NILP, 0);
    chk("R7 rooted record survives", 32'(r_ptr), 32'(atm(5)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_nonlist();
    t_hold();
    t_fill();
    t_gc();
    t_oom();
    t_recover();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    finish_run();
  end
endmodule